// File: doc/BRIEF.md
# Latched 64-bit Free-Running Counter

The block keeps a 64-bit up-counter that advances by one on every cycle in which a tick-enable input is high. That input stands for the oscillator clock. Software reaches the counter through a small register bus. The bus carries one control register and two 32-bit read-only snapshot words.

The counter is never read live. Software sets a latch request bit in the control register and polls that bit until the hardware drops it. It then reads the low snapshot word and after it the high word. Both words come from the same capture.

Zeroing works the same way. A clear request bit is set and polled until it self-clears. Each request finishes a fixed number of cycles after the write (three by default). This latency models the crossing into a separate counter clock domain.

Top module: `cnt64_latch_top`

## Requirements
- R1: After reset the counter and both snapshot words are zero, and the control register reads 0.
- R2: The counter rises by one at each clock edge where `tick_en` is high, and it holds while `tick_en` is low.
- R3: Writing a 1 to bit 0 of the control register (offset 0xA0) starts a clear. Bit 0 reads 1 for the three cycles after the write. At the third edge after the write the counter becomes zero and bit 0 reads 0. The clear takes priority over a tick on that edge.
- R4: Writing a 1 to bit 1 of the control register starts a latch. Bit 1 reads 1 for the three cycles after the write. At the third edge after the write, the count held before that edge is copied into the snapshot.
- R5: The snapshot keeps its value until the next latch completes. Reading the snapshot words any number of times does not change them.
- R6: When bits 0 and 1 are written in the same write, the clear is applied first and the latch captures zero.
- R7: The counter wraps from all ones to zero on the next tick.
- R8: The low snapshot word at offset 0xA4 holds count bits [31:0] and the high word at 0xA8 holds bits [63:32]. Both words come from the same capture, even when the counter moves between the two reads.
- R9: The following writes have no effect:
  - a write of 0 to the control register;
  - a write to either snapshot word;
  - a write to any other offset;
  - a request write while that request is already pending. It neither restarts nor extends the pending request.
  Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable, one increment per high cycle |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |

## Verification
A wrong value in a request's countdown shows up as a busy bit that drops one cycle early or late. The back-to-back control polls after each request catch this at the first poll that disagrees. A counter that slips or misses a clear stays hidden until the next completed latch, so every clear is followed by a latch and a snapshot read. A snapshot disturbed by reads or by counter motion appears on the next read of either word, which is why each snapshot is read twice with ticks in between.

// File: rtl/cnt64_pkg.sv
// Shared constants for the latched counter: register offsets and
// request bit positions. Assumes byte offsets on the register bus.
package cnt64_pkg;
    localparam logic [7:0] ADR_CTRL    = 8'hA0;
    localparam logic [7:0] ADR_SNAP_LO = 8'hA4;
    localparam logic [7:0] ADR_SNAP_HI = 8'hA8;

    // request bit positions inside the control register
    localparam int unsigned CTL_CLR_BIT   = 0;
    localparam int unsigned CTL_LATCH_BIT = 1;
    localparam int unsigned NUM_REQ       = 2;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_LO,
        SEL_HI
    } reg_sel_e;
endpackage

// File: rtl/cnt64_req_track.sv
// One self-clearing request bit. A start while idle raises busy and
// arms a countdown of LAT cycles; fire pulses in the last busy cycle,
// and busy drops at that edge. Starts while busy are ignored.
// Assumes LAT >= 1.
module cnt64_req_track #(
    parameter int unsigned LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fire
);
    localparam int unsigned CW = (LAT > 1) ? $clog2(LAT) : 1;

    logic [CW-1:0] remain;

    assign fire = busy && (remain == '0);

    // arm, count down and retire the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (fire) begin
            busy   <= 1'b0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            remain <= CW'(LAT - 1);
        end else if (busy) begin
            remain <= remain - 1'b1;
        end
    end

    // checker: consecutive busy cycles, bounded by LAT
    logic [CW:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) age <= '0;
        else                 age <= age + 1'b1;
    end

    p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (age < (CW+1)'(LAT)));
    p_fire_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !busy);
    p_start_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fire) |=> (busy && remain == $past(remain) - 1'b1));
endmodule

// File: rtl/cnt64_core.sv
// Counter and snapshot storage. The count clears on clr_fire (which
// beats a tick) and otherwise rises on tick. On lat_fire the snapshot
// takes the pre-edge count, or zero when a clear fires in the same
// cycle. Assumes the fire inputs are single-cycle pulses.
module cnt64_core #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr_fire,
    input  logic             lat_fire,
    output logic [CNT_W-1:0] snap
);
    logic [CNT_W-1:0] count;

    // free-running count with clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (clr_fire) count <= '0;
        else if (tick)     count <= count + 1'b1;
    end

    // snapshot capture, clear ordered before latch
    always_ff @(posedge clk) begin
        if (!rst_n)        snap <= '0;
        else if (lat_fire) snap <= clr_fire ? '0 : count;
    end

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_fire) |=> (count == $past(count) + 1'b1));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr_fire) |=> $stable(count));
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> (count == '0));
    p_latch_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_fire && !clr_fire) |=> (snap == $past(count)));
    p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_fire |=> $stable(snap));
    p_both_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_fire && clr_fire) |=> (snap == '0));
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_fire && (&count)) |=> (count == '0));
endmodule

// File: rtl/cnt64_latch_top.sv
// Register front end of the latched counter. Decodes the control and
// snapshot offsets, starts one request tracker per control bit, and
// returns combinational read data. The counter is 2*WORD_W wide and
// is seen only through the snapshot. Assumes WORD_W >= NUM_REQ + 1.
module cnt64_latch_top #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned SYNC_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);
    import cnt64_pkg::*;

    localparam int unsigned CNT_W = 2 * WORD_W;

    reg_sel_e           hit;
    logic               wr_ctrl;
    logic [NUM_REQ-1:0] req_start;
    logic [NUM_REQ-1:0] req_busy;
    logic [NUM_REQ-1:0] req_fire;
    logic [CNT_W-1:0]   snap;
    logic               unused_wdata_hi;

    // address decode to a register select
    always_comb begin
        if (bus_addr == ADDR_W'(ADR_CTRL))         hit = SEL_CTRL;
        else if (bus_addr == ADDR_W'(ADR_SNAP_LO)) hit = SEL_LO;
        else if (bus_addr == ADDR_W'(ADR_SNAP_HI)) hit = SEL_HI;
        else                                       hit = SEL_NONE;
    end

    assign wr_ctrl         = bus_sel && bus_wr && (hit == SEL_CTRL);
    assign unused_wdata_hi = ^bus_wdata[WORD_W-1:NUM_REQ];

    // one tracker per request bit
    generate
        for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
            assign req_start[g] = wr_ctrl && bus_wdata[g];
            cnt64_req_track #(.LAT(SYNC_LAT)) u_trk (
                .clk   (clk),
                .rst_n (rst_n),
                .start (req_start[g]),
                .busy  (req_busy[g]),
                .fire  (req_fire[g])
            );
        end
    endgenerate

    cnt64_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .clr_fire (req_fire[CTL_CLR_BIT]),
        .lat_fire (req_fire[CTL_LATCH_BIT]),
        .snap     (snap)
    );

    // read data multiplexer, unmapped offsets read zero
    always_comb begin
        bus_rdata = '0;
        case (hit)
            SEL_CTRL: bus_rdata[NUM_REQ-1:0] = req_busy;
            SEL_LO:   bus_rdata = snap[WORD_W-1:0];
            SEL_HI:   bus_rdata = snap[CNT_W-1:WORD_W];
            default:  bus_rdata = '0;
        endcase
    end

    p_ctrl_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && hit != SEL_CTRL && req_busy == '0) |=> (req_busy == '0));
    p_zero_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[NUM_REQ-1:0] == '0 && req_busy == '0) |=> (req_busy == '0));
    p_snap_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && hit == SEL_LO && req_fire[CTL_LATCH_BIT] == 1'b0)
            |=> $stable(snap));
endmodule

// File: tb/sim_cnt64_latch_top.sv
`timescale 1ns/1ps
module sim_cnt64_latch_top;
    localparam logic [7:0] A_CTRL = 8'hA0;
    localparam logic [7:0] A_LO   = 8'hA4;
    localparam logic [7:0] A_HI   = 8'hA8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n  = 1'b0;
    logic        tick   = 1'b0;
    logic        sel    = 1'b0;
    logic        wr     = 1'b0;
    logic [7:0]  addr   = '0;
    logic [31:0] wdata  = '0;
    logic [31:0] rdata;

    logic        tick1  = 1'b0;
    logic        sel1   = 1'b0;
    logic        wr1    = 1'b0;
    logic [7:0]  addr1  = '0;
    logic [3:0]  wdata1 = '0;
    logic [3:0]  rdata1;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    cnt64_latch_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
    );

    // narrow variant: 8-bit counter, 4-bit words, for wrap and word split
    cnt64_latch_top #(.WORD_W(4)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick1), .bus_sel(sel1), .bus_wr(wr1),
        .bus_addr(addr1), .bus_wdata(wdata1), .bus_rdata(rdata1)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expectation per read cycle of u0
    always begin : mon
        logic [31:0] e;
        string       t;
        @(negedge clk);
        #1;
        if (sel && !wr) begin
            if (exp_q.size() == 0) begin
                check("SB unexpected read", rdata, 32'hx);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rdata, e);
            end
        end
    end

    // driver tasks for u0
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk);
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d; tick = tk;
        @(posedge clk);
    endtask

    task automatic idle(input int n, input logic tk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sel = 1'b0; wr = 1'b0; tick = tk;
            @(posedge clk);
        end
    endtask

    task automatic poll(input logic [31:0] busy, input string t);
        for (int i = 0; i < 3; i++) rd(A_CTRL, busy, t);
        rd(A_CTRL, 32'h0, t);
    endtask

    task automatic latch_read(input logic [31:0] lo, input logic [31:0] hi, input string t);
        wreg(A_CTRL, 32'h2, 1'b0);
        poll(32'h2, t);
        rd(A_LO, lo, t);
        rd(A_HI, hi, t);
    endtask

    // driver tasks for u1
    task automatic pulse1(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick1 = 1'b1;
            @(posedge clk);
        end
        @(negedge clk); tick1 = 1'b0;
    endtask

    task automatic latch1;
        @(negedge clk); sel1 = 1'b1; wr1 = 1'b1; addr1 = A_CTRL; wdata1 = 4'h2;
        @(negedge clk); sel1 = 1'b0; wr1 = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd1(input logic [7:0] a, input logic [3:0] e, input string t);
        @(negedge clk); sel1 = 1'b1; wr1 = 1'b0; addr1 = a;
        #1 check(t, {28'h0, rdata1}, {28'h0, e});
        @(negedge clk); sel1 = 1'b0;
    endtask

    initial begin
        idle(3, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, 32'h0, "R1 ctrl");
        rd(A_LO, 32'h0, "R1 lo");
        rd(A_HI, 32'h0, "R1 hi");

        // R2 five ticks then hold; R4 latch timing and value
        idle(5, 1'b1);
        idle(2, 1'b0);
        latch_read(32'd5, 32'h0, "R2 R4 latch after 5 ticks");

        // R4 capture while ticking: 5 + 3 edges before capture edge
        wreg(A_CTRL, 32'h2, 1'b1);
        poll(32'h2, "R4 busy while ticking");
        idle(1, 1'b0);
        rd(A_LO, 32'd8, "R4 capture value");

        // R5 snapshot stable across ticks and repeated reads
        idle(10, 1'b1);
        idle(1, 1'b0);
        rd(A_LO, 32'd8, "R5 first read");
        rd(A_LO, 32'd8, "R5 second read");
        rd(A_HI, 32'h0, "R5 hi");

        // R3 clear then latch
        wreg(A_CTRL, 32'h1, 1'b0);
        poll(32'h1, "R3 clear busy");
        latch_read(32'h0, 32'h0, "R3 cleared count");
        idle(3, 1'b1);
        idle(1, 1'b0);
        latch_read(32'd3, 32'h0, "R3 count after clear");

        // R6 clear and latch together
        idle(4, 1'b1);
        idle(1, 1'b0);
        wreg(A_CTRL, 32'h3, 1'b0);
        poll(32'h3, "R6 both busy");
        rd(A_LO, 32'h0, "R6 lo zero");
        rd(A_HI, 32'h0, "R6 hi zero");
        idle(2, 1'b1);
        idle(1, 1'b0);
        latch_read(32'd2, 32'h0, "R6 counter was cleared");

        // R9 ignored writes
        wreg(A_CTRL, 32'h0, 1'b0);
        rd(A_CTRL, 32'h0, "R9 zero write");
        wreg(A_LO, 32'hDEAD_BEEF, 1'b0);
        rd(A_LO, 32'd2, "R9 lo read-only");
        wreg(A_HI, 32'h1234_5678, 1'b0);
        rd(A_HI, 32'h0, "R9 hi read-only");
        rd(8'hAC, 32'h0, "R9 unmapped read");
        wreg(8'hB0, 32'h3, 1'b0);
        rd(A_CTRL, 32'h0, "R9 unmapped write");
        wreg(A_CTRL, 32'h2, 1'b0);
        wreg(A_CTRL, 32'h2, 1'b0);
        rd(A_CTRL, 32'h2, "R9 re-request");
        rd(A_CTRL, 32'h2, "R9 re-request");
        rd(A_CTRL, 32'h0, "R9 re-request not restarted");
        idle(2, 1'b0);

        // R8 word split from one snapshot, R7 wrap, on the narrow variant
        pulse1(55);
        latch1();
        pulse1(3);
        rd1(A_LO, 4'h7, "R8 low word");
        rd1(A_HI, 4'h3, "R8 high word same snapshot");
        pulse1(197);
        latch1();
        rd1(A_LO, 4'hF, "R7 all ones lo");
        rd1(A_HI, 4'hF, "R7 all ones hi");
        pulse1(1);
        latch1();
        rd1(A_LO, 4'h0, "R7 wrapped lo");
        rd1(A_HI, 4'h0, "R7 wrapped hi");

        idle(3, 1'b0);
        if (exp_q.size() != 0) check("SB leftover", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule